// File: doc/BRIEF.md
# Reed-Solomon Codeword Replay and Correction Stage

This block is the last stage of a Reed-Solomon decoder for codewords of 255 eight-bit symbols, 16 of them parity. Symbols arrive as a valid-qualified stream, and a start flag marks the first symbol of each codeword. The block stores each codeword until two things are true: the whole codeword has arrived, and the upstream error-magnitude stage has delivered that codeword's error list. The list holds up to eight (position, value) pairs, a done strobe and a verdict on whether the codeword can be corrected. The block then replays the codeword one symbol per cycle. It XORs each listed error value onto the symbol at the matching position.

Each output symbol comes with a start flag on the first symbol of the codeword and a marker on every symbol that correction changed. The codeword's error count and an uncorrectable flag are held on the output for the whole codeword. A decode enable turns correction off so that stored symbols pass out raw. Storage for two codewords lets one codeword be replayed while the next is being received. If an error list is late, replay waits, and no symbol is dropped.

Top module: `rsc_corrector`

## Requirements
- R1: While reset is high and after it is released, out_valid, out_sof and out_fixed are low, and out_nerr and out_data are zero, until a codeword is replayed. Reset is asynchronous and active high.
- R2: in_data and in_sof are sampled only on rising edges where in_valid is high. Idle cycles, including any level on in_sof during them, do not change the stored codeword.
- R3: in_sof marks symbol position 0, and each codeword is 255 valid symbols. On output, codewords leave as runs of exactly 255 out_valid symbols. out_sof is high with the first symbol of each run and low on all others.
- R4: Replay of a codeword begins only when all 255 of its symbols and its error-list done strobe have arrived. While either is missing, out_valid stays low.
- R5: With out_valid and correction applied, out_data equals the stored symbol XOR the error value of every list entry whose position equals the symbol's position. Position p is the p-th symbol after in_sof, counted from 0.
- R6: out_fixed is high exactly on output symbols whose value differs from the stored symbol.
- R7: out_nerr (4 bits) equals the number of entries in the codeword's error list, at most 8, on every symbol of that codeword when correction is applied.
- R8: A codeword whose done strobe came with err_uncorr high leaves unmodified, with out_bad high, out_nerr zero and out_fixed low on all its symbols.
- R9: With corr_en low, output symbols equal the stored symbols, out_fixed is low and out_nerr is zero.
- R10: While out_valid is low, out_data holds its last value.
- R11: Two codewords can be held at once, and codewords leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| corr_en | input | 1 | 1 applies corrections, 0 gives raw output |
| in_valid | input | 1 | Input symbol qualifier |
| in_sof | input | 1 | First symbol of a codeword |
| in_data | input | 8 | Input symbol |
| err_valid | input | 1 | One error-list entry this cycle |
| err_pos | input | 8 | Symbol position of the entry, 0 to 254 |
| err_val | input | 8 | Error value to XOR at that position |
| err_done | input | 1 | Error list for the oldest pending codeword is complete |
| err_uncorr | input | 1 | With err_done: codeword cannot be corrected |
| out_valid | output | 1 | Output symbol qualifier |
| out_sof | output | 1 | First output symbol of a codeword |
| out_data | output | 8 | Output symbol |
| out_fixed | output | 1 | Symbol was changed by correction |
| out_nerr | output | 4 | Errors corrected in the current codeword |
| out_bad | output | 1 | Current codeword is uncorrectable |

## Verification
The bench puts errors at positions 0 and 254 and fills a list to all eight entries. A wrong position count or an off-by-one list bound would then show as a corrupted first or last symbol, or as a wrong count. It holds back two error lists while both codewords sit in storage. A design that started replay without the list would raise out_valid during that wait, and one that mixed up slots would emit the codewords out of order or with the other codeword's errors. It drives random in_sof levels on idle input cycles, which would shift the frame in a design that sampled without in_valid. It also checks uncorrectable and bypassed codewords, where a leaked XOR or a nonzero count would show directly.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int RS_N       = 255;
  localparam int RS_SYM_W   = 8;
  localparam int RS_MAX_ERR = 8;
  localparam int RS_SLOTS   = 2;

  function automatic int ptr_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rsc_sym_store.sv
module rsc_sym_store
  import rsc_pkg::*;
#(
  parameter int N_SYM = RS_N,
  parameter int SYM_W = RS_SYM_W,
  parameter int SLOTS = RS_SLOTS,
  localparam int IDX_W  = $clog2(N_SYM),
  localparam int SLOT_W = ptr_w(SLOTS),
  localparam int ADDR_W = $clog2(N_SYM * SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [SYM_W-1:0]  in_data,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_release,
  output logic [SYM_W-1:0]  rd_data,
  output logic [SLOTS-1:0]  full
);
  logic [SYM_W-1:0]  mem [N_SYM*SLOTS];
  logic [SLOT_W-1:0] wslot_q, wslot_d;
  logic [IDX_W-1:0]  widx_q, widx_d, widx_eff;
  logic [SLOTS-1:0]  full_q, full_d;
  logic              wr_en;
  logic [ADDR_W-1:0] waddr, raddr;

  always_comb begin
    widx_eff = in_sof ? '0 : widx_q;
    wr_en    = in_valid && !full_q[wslot_q];
    waddr    = ADDR_W'(wslot_q) * ADDR_W'(N_SYM) + ADDR_W'(widx_eff);
    raddr    = ADDR_W'(rd_slot) * ADDR_W'(N_SYM) + ADDR_W'(rd_idx);
    wslot_d  = wslot_q;
    widx_d   = widx_q;
    full_d   = full_q;
    if (rd_release) full_d[rd_slot] = 1'b0;
    if (wr_en) begin
      if (widx_eff == IDX_W'(N_SYM - 1)) begin
        full_d[wslot_q] = 1'b1;
        widx_d          = '0;
        wslot_d         = (wslot_q == SLOT_W'(SLOTS - 1)) ? '0 : wslot_q + SLOT_W'(1);
      end else begin
        widx_d = widx_eff + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wslot_q <= '0;
      widx_q  <= '0;
      full_q  <= '0;
    end else begin
      wslot_q <= wslot_d;
      widx_q  <= widx_d;
      full_q  <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= in_data;
  end

  assign rd_data = mem[raddr];
  assign full    = full_q;
endmodule

// File: rtl/rsc_err_table.sv
module rsc_err_table
  import rsc_pkg::*;
#(
  parameter int N_SYM   = RS_N,
  parameter int SYM_W   = RS_SYM_W,
  parameter int MAX_ERR = RS_MAX_ERR,
  parameter int SLOTS   = RS_SLOTS,
  localparam int IDX_W  = $clog2(N_SYM),
  localparam int SLOT_W = ptr_w(SLOTS),
  localparam int CNT_W  = $clog2(MAX_ERR + 1),
  localparam int ENT_W  = ptr_w(MAX_ERR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_valid,
  input  logic [IDX_W-1:0]  err_pos,
  input  logic [SYM_W-1:0]  err_val,
  input  logic              err_done,
  input  logic              err_uncorr,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_release,
  output logic [SYM_W-1:0]  rd_mask,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic              rd_bad,
  output logic [SLOTS-1:0]  ready
);
  logic [IDX_W-1:0]  pos_q [SLOTS][MAX_ERR];
  logic [SYM_W-1:0]  val_q [SLOTS][MAX_ERR];
  logic [CNT_W-1:0]  cnt_q [SLOTS];
  logic [CNT_W-1:0]  cnt_d [SLOTS];
  logic [SLOTS-1:0]  ready_q, ready_d, bad_q, bad_d;
  logic [SLOT_W-1:0] wslot_q, wslot_d;
  logic              store_en;
  logic [ENT_W-1:0]  store_at;
  logic [MAX_ERR-1:0] hit;

  always_comb begin
    store_en = err_valid && (cnt_q[wslot_q] < CNT_W'(MAX_ERR));
    store_at = cnt_q[wslot_q][ENT_W-1:0];
    cnt_d    = cnt_q;
    ready_d  = ready_q;
    bad_d    = bad_q;
    wslot_d  = wslot_q;
    if (rd_release) begin
      cnt_d[rd_slot]   = '0;
      ready_d[rd_slot] = 1'b0;
      bad_d[rd_slot]   = 1'b0;
    end
    if (store_en) cnt_d[wslot_q] = cnt_q[wslot_q] + CNT_W'(1);
    if (err_done) begin
      ready_d[wslot_q] = 1'b1;
      bad_d[wslot_q]   = err_uncorr;
      wslot_d          = (wslot_q == SLOT_W'(SLOTS - 1)) ? '0 : wslot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int s = 0; s < SLOTS; s++) cnt_q[s] <= '0;
      ready_q <= '0;
      bad_q   <= '0;
      wslot_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
      bad_q   <= bad_d;
      wslot_q <= wslot_d;
    end
  end

  always_ff @(posedge clk) begin
    if (store_en) begin
      pos_q[wslot_q][store_at] <= err_pos;
      val_q[wslot_q][store_at] <= err_val;
    end
  end

  // one position comparator per list entry
  for (genvar j = 0; j < MAX_ERR; j++) begin : g_hit
    assign hit[j] = (CNT_W'(j) < cnt_q[rd_slot]) && (pos_q[rd_slot][j] == rd_idx);
  end

  always_comb begin
    rd_mask = '0;
    for (int j = 0; j < MAX_ERR; j++) begin
      if (hit[j]) rd_mask = rd_mask ^ val_q[rd_slot][j];
    end
  end

  assign rd_cnt = cnt_q[rd_slot];
  assign rd_bad = bad_q[rd_slot];
  assign ready  = ready_q;
endmodule

// File: rtl/rsc_out_ctrl.sv
module rsc_out_ctrl
  import rsc_pkg::*;
#(
  parameter int N_SYM   = RS_N,
  parameter int SYM_W   = RS_SYM_W,
  parameter int MAX_ERR = RS_MAX_ERR,
  parameter int SLOTS   = RS_SLOTS,
  localparam int IDX_W  = $clog2(N_SYM),
  localparam int SLOT_W = ptr_w(SLOTS),
  localparam int CNT_W  = $clog2(MAX_ERR + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              corr_en,
  input  logic [SLOTS-1:0]  avail,
  input  logic [SYM_W-1:0]  rd_data,
  input  logic [SYM_W-1:0]  rd_mask,
  input  logic [CNT_W-1:0]  rd_cnt,
  input  logic              rd_bad,
  output logic [SLOT_W-1:0] rd_slot,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              rd_release,
  output logic              out_valid,
  output logic              out_sof,
  output logic [SYM_W-1:0]  out_data,
  output logic              out_fixed,
  output logic [CNT_W-1:0]  out_nerr,
  output logic              out_bad
);
  logic              run_q, run_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SLOT_W-1:0] slot_q, slot_d, slot_nx;
  logic              last, start, apply;
  logic              ov_q, ov_d, sof_q, sof_d, fix_q, fix_d, bad_q, bad_d;
  logic [SYM_W-1:0]  dat_q, dat_d;
  logic [CNT_W-1:0]  ner_q, ner_d;

  always_comb begin
    slot_nx = (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + SLOT_W'(1);
    last    = run_q && (idx_q == IDX_W'(N_SYM - 1));
    start   = !run_q && avail[slot_q];
    apply   = corr_en && !rd_bad;
    run_d   = run_q;
    if (start)     run_d = 1'b1;
    else if (last) run_d = avail[slot_nx];
    idx_d  = (run_q && !last) ? idx_q + IDX_W'(1) : '0;
    slot_d = last ? slot_nx : slot_q;
    ov_d   = run_q;
    sof_d  = run_q && (idx_q == '0);
    fix_d  = run_q && apply && (rd_mask != '0);
    dat_d  = dat_q;
    ner_d  = ner_q;
    bad_d  = bad_q;
    if (run_q) begin
      dat_d = rd_data ^ (apply ? rd_mask : '0);
      ner_d = apply ? rd_cnt : '0;
      bad_d = rd_bad;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      slot_q <= '0;
      ov_q   <= 1'b0;
      sof_q  <= 1'b0;
      fix_q  <= 1'b0;
      dat_q  <= '0;
      ner_q  <= '0;
      bad_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      idx_q  <= idx_d;
      slot_q <= slot_d;
      ov_q   <= ov_d;
      sof_q  <= sof_d;
      fix_q  <= fix_d;
      dat_q  <= dat_d;
      ner_q  <= ner_d;
      bad_q  <= bad_d;
    end
  end

  assign rd_slot    = slot_q;
  assign rd_idx     = idx_q;
  assign rd_release = last;
  assign out_valid  = ov_q;
  assign out_sof    = sof_q;
  assign out_data   = dat_q;
  assign out_fixed  = fix_q;
  assign out_nerr   = ner_q;
  assign out_bad    = bad_q;
endmodule

// File: rtl/rsc_corrector.sv
module rsc_corrector
  import rsc_pkg::*;
#(
  parameter int N_SYM   = RS_N,
  parameter int SYM_W   = RS_SYM_W,
  parameter int MAX_ERR = RS_MAX_ERR,
  parameter int SLOTS   = RS_SLOTS,
  localparam int IDX_W  = $clog2(N_SYM),
  localparam int SLOT_W = ptr_w(SLOTS),
  localparam int CNT_W  = $clog2(MAX_ERR + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             corr_en,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [SYM_W-1:0] in_data,
  input  logic             err_valid,
  input  logic [IDX_W-1:0] err_pos,
  input  logic [SYM_W-1:0] err_val,
  input  logic             err_done,
  input  logic             err_uncorr,
  output logic             out_valid,
  output logic             out_sof,
  output logic [SYM_W-1:0] out_data,
  output logic             out_fixed,
  output logic [CNT_W-1:0] out_nerr,
  output logic             out_bad
);
  logic [SLOTS-1:0]  full, ready;
  logic [SLOT_W-1:0] rd_slot;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_release, rd_bad;
  logic [SYM_W-1:0]  rd_data, rd_mask;
  logic [CNT_W-1:0]  rd_cnt;

  rsc_sym_store #(.N_SYM(N_SYM), .SYM_W(SYM_W), .SLOTS(SLOTS)) u_store (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_release(rd_release),
    .rd_data(rd_data), .full(full)
  );

  rsc_err_table #(.N_SYM(N_SYM), .SYM_W(SYM_W), .MAX_ERR(MAX_ERR), .SLOTS(SLOTS)) u_errs (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_pos(err_pos), .err_val(err_val),
    .err_done(err_done), .err_uncorr(err_uncorr),
    .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_release(rd_release),
    .rd_mask(rd_mask), .rd_cnt(rd_cnt), .rd_bad(rd_bad), .ready(ready)
  );

  rsc_out_ctrl #(.N_SYM(N_SYM), .SYM_W(SYM_W), .MAX_ERR(MAX_ERR), .SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rst(rst), .corr_en(corr_en), .avail(full & ready),
    .rd_data(rd_data), .rd_mask(rd_mask), .rd_cnt(rd_cnt), .rd_bad(rd_bad),
    .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_release(rd_release),
    .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data),
    .out_fixed(out_fixed), .out_nerr(out_nerr), .out_bad(out_bad)
  );
endmodule

// File: rtl/rsc_corrector_chk.sv
module rsc_corrector_chk #(
  parameter int N_SYM   = 255,
  parameter int SYM_W   = 8,
  parameter int MAX_ERR = 8,
  localparam int CNT_W  = $clog2(MAX_ERR + 1),
  localparam int RUN_W  = $clog2(N_SYM + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             corr_en,
  input logic             out_valid,
  input logic             out_sof,
  input logic [SYM_W-1:0] out_data,
  input logic             out_fixed,
  input logic [CNT_W-1:0] out_nerr,
  input logic             out_bad
);
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) run_len <= '0;
    else if (out_valid) run_len <= out_sof ? RUN_W'(1) : run_len + RUN_W'(1);
  end

  assert_sof_valid_R3: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
  assert_frame_start_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sof) |-> (run_len == '0 || run_len == RUN_W'(N_SYM)));
  assert_frame_body_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sof) |-> (run_len != '0 && run_len < RUN_W'(N_SYM)));
  assert_fixed_valid_R6: assert property (@(posedge clk) disable iff (rst)
    out_fixed |-> out_valid);
  assert_count_max_R7: assert property (@(posedge clk) disable iff (rst)
    out_nerr <= CNT_W'(MAX_ERR));
  assert_bad_raw_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_bad) |-> (out_nerr == '0 && !out_fixed));
  assert_bypass_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(corr_en)) |-> (out_nerr == '0 && !out_fixed));
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
endmodule

bind rsc_corrector rsc_corrector_chk #(.N_SYM(N_SYM), .SYM_W(SYM_W), .MAX_ERR(MAX_ERR)) u_chk (
  .clk(clk), .rst(rst), .corr_en(corr_en), .out_valid(out_valid), .out_sof(out_sof),
  .out_data(out_data), .out_fixed(out_fixed), .out_nerr(out_nerr), .out_bad(out_bad)
);

// File: tb/rsc_corrector_test.sv
module rsc_corrector_test;
  localparam int N = 255;
  localparam int ME = 8;
  localparam int NCW = 10;

  logic clk = 1'b0;
  logic rst;
  logic corr_en, in_valid, in_sof, err_valid, err_done, err_uncorr;
  logic [7:0] in_data, err_pos, err_val, out_data;
  logic out_valid, out_sof, out_fixed, out_bad;
  logic [3:0] out_nerr;

  always #5 clk = ~clk;

  rsc_corrector uut (
    .clk(clk), .rst(rst), .corr_en(corr_en), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .err_valid(err_valid), .err_pos(err_pos), .err_val(err_val),
    .err_done(err_done), .err_uncorr(err_uncorr), .out_valid(out_valid), .out_sof(out_sof),
    .out_data(out_data), .out_fixed(out_fixed), .out_nerr(out_nerr), .out_bad(out_bad)
  );

  logic [7:0] cw_sym [NCW][N];
  logic [7:0] e_pos  [NCW][ME];
  logic [7:0] e_val  [NCW][ME];
  int         e_n    [NCW];
  bit         e_bad  [NCW];
  bit         e_en   [NCW];

  int checks = 0, fails = 0, cyc = 0;
  int out_cw = 0, out_idx = 0, stall_valid = 0;
  bit monitor_on = 0, stall_watch = 0;
  logic [7:0] last_data = 8'h00;
  int unused_seed;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (codeword %0d symbol %0d)", req, act, exp, out_cw, out_idx);
    end
  endtask

  function automatic logic [7:0] err_mask(input int k, input int i);
    logic [7:0] m = 8'h00;
    for (int j = 0; j < e_n[k]; j++) if (int'(e_pos[k][j]) == i) m ^= e_val[k][j];
    return m;
  endfunction

  // mode 0: random count, 1: eight errors touching positions 0 and 254, 2: none, 3: uncorrectable
  task automatic gen_cw(input int k, input int mode);
    for (int i = 0; i < N; i++) cw_sym[k][i] = 8'($urandom);
    e_n[k] = (mode == 1 || mode == 3) ? ME : (mode == 2) ? 0 : int'($urandom % (ME + 1));
    for (int j = 0; j < ME; j++) begin
      e_pos[k][j] = 8'(j * 31 + int'($urandom % 31));
      e_val[k][j] = 8'(($urandom % 255) + 1);
    end
    if (mode == 1) begin
      e_pos[k][0] = 8'd0;
      e_pos[k][ME-1] = 8'd254;
    end
    e_bad[k] = (mode == 3);
    e_en[k]  = corr_en;
  endtask

  // R2: idle cycles carry garbage data and random start flags
  task automatic send_data(input int k);
    for (int i = 0; i < N; i++) begin
      if ($urandom % 8 == 0) begin
        for (int g = 0; g < int'($urandom % 3) + 1; g++) begin
          in_valid = 1'b0;
          in_sof   = 1'($urandom);
          in_data  = 8'($urandom);
          @(negedge clk);
        end
      end
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_data  = cw_sym[k][i];
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic send_err(input int k);
    for (int j = 0; j < e_n[k]; j++) begin
      err_valid = 1'b1;
      err_pos   = e_pos[k][j];
      err_val   = e_val[k][j];
      @(negedge clk);
    end
    err_valid  = 1'b0;
    err_done   = 1'b1;
    err_uncorr = e_bad[k];
    @(negedge clk);
    err_done   = 1'b0;
    err_uncorr = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic drain(input int target);
    while (out_cw < target) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d (output codewords)", out_cw, NCW);
      finish_run();
    end
    if (monitor_on && !rst) begin
      if (out_valid) begin
        if (stall_watch) stall_valid++;
        if (out_cw >= NCW) begin
          check(1'b0, "R3 extra symbol", out_cw, NCW - 1);
        end else begin
          logic [7:0] m, exp_d;
          bit apply;
          string dtag;
          m = err_mask(out_cw, out_idx);
          apply = e_en[out_cw] && !e_bad[out_cw];
          exp_d = cw_sym[out_cw][out_idx] ^ (apply ? m : 8'h00);
          dtag = e_bad[out_cw] ? "R8 data" : (!e_en[out_cw] ? "R9 data" : "R5 data");
          check(out_data == exp_d, dtag, out_data, exp_d);
          check(out_sof == (out_idx == 0), "R3 sof", out_sof, out_idx == 0);
          check(out_fixed == (apply && m != 8'h00), "R6 fixed", out_fixed, apply && m != 8'h00);
          check(int'(out_nerr) == (apply ? e_n[out_cw] : 0), e_bad[out_cw] ? "R8 count" : "R7 count",
                out_nerr, apply ? e_n[out_cw] : 0);
          check(out_bad == e_bad[out_cw], "R8 flag", out_bad, e_bad[out_cw]);
          last_data = out_data;
          out_idx++;
          if (out_idx == N) begin
            out_idx = 0;
            out_cw++;
          end
        end
      end else begin
        check(out_data == last_data, "R10 hold", out_data, last_data);
        check(!out_sof && !out_fixed, "R3 flags idle", {out_sof, out_fixed}, 0);
      end
    end
  end

  initial begin
    unused_seed = $urandom(32'd20240611);
    rst = 1'b1;
    corr_en = 1'b1;
    in_valid = 1'b0; in_sof = 1'b0; in_data = 8'h00;
    err_valid = 1'b0; err_pos = 8'h00; err_val = 8'h00; err_done = 1'b0; err_uncorr = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid && !out_sof && !out_fixed && out_nerr == 0 && out_data == 0, "R1 in reset",
          {out_valid, out_sof, out_fixed, out_nerr}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !out_sof && !out_fixed && out_nerr == 0 && out_data == 0, "R1 after reset",
          {out_valid, out_sof, out_fixed, out_nerr}, 0);
    monitor_on = 1;

    // streamed codewords, correction on: R2 R3 R5 R6 R7 R8 R11
    for (int k = 0; k < 6; k++) begin
      gen_cw(k, (k == 1 || k == 5) ? 1 : (k == 2) ? 2 : (k == 3) ? 3 : 0);
      send_data(k);
      send_err(k);
    end
    drain(6);

    // R9: bypass with a full error list
    corr_en = 1'b0;
    gen_cw(6, 1);
    send_data(6);
    send_err(6);
    drain(7);
    corr_en = 1'b1;

    // R4 and R11: both slots filled, error lists held back
    gen_cw(7, 1);
    gen_cw(8, 0);
    send_data(7);
    send_data(8);
    stall_watch = 1;
    repeat (60) @(negedge clk);
    stall_watch = 0;
    check(stall_valid == 0, "R4 stall", stall_valid, 0);
    send_err(7);
    send_err(8);
    drain(9);

    gen_cw(9, 2);
    send_data(9);
    send_err(9);
    drain(10);
    repeat (20) @(negedge clk);
    check(out_cw == NCW && out_idx == 0, "R11 codeword count", out_cw, NCW);
    finish_run();
  end
endmodule